// File: doc/BRIEF.md
# OTP row read sequencer

This block sits on a byte-wide parallel bus in front of a nonvolatile memory. Besides the main array (32 KB, whose read data arrives on `arr_rdata`), there is a separate 64-byte one-time-programmable row, held here as a register array that is loaded with fixed contents at reset. Normally every bus read returns main-array data.

The controller can switch reads over to the hidden row. It does this by writing three exact address/data pairs in a row. After that, any read with a sector select active and address bit 6 clear returns the row byte picked by address bits 5..0. The controller can read any number of row bytes. It then writes a return command, and normal array reads resume. A wrong write partway through the unlock abandons it. Read data is registered, so it appears one cycle after the read strobe, together with a one-cycle valid pulse.

Top module: `otp_row_seq`

## Requirements
- R1: While reset is active, and until the unlock sequence completes after reset, the block is in normal mode: `rd_valid` is 0, `rd_data` is 0x00, and reads return array data, even if row mode was active before reset.
- R2: Three writes, in order (0x555, 0xAA), (0x2AA, 0x55), (0x555, 0x90), enter row mode. Reads between these writes do not disturb the sequence.
- R3: After the first key write, if the next write does not match the expected next pair in both address and data, the unlock is dropped and the block returns to normal mode. A write that misses the first key leaves the block in normal mode.
- R4: In row mode, a read with any `sect_sel` bit set and address bit 6 = 0 returns row byte k, where k = address bits 5..0. Byte k holds (7·k + 0x5C) mod 256.
- R5: In row mode, a read with address bit 6 = 1 returns `arr_rdata` and does not leave row mode.
- R6: In row mode, a read with `sect_sel` all zero returns `arr_rdata`.
- R7: In row mode, a write with data 0xF0, at any address, returns the block to normal mode. Any other write in row mode is ignored.
- R8: `rd_valid` pulses for exactly one cycle, in the cycle after a `bus_rd` cycle. `rd_data` keeps its value until the next read.
- R9: In normal mode, every read returns the `arr_rdata` value present in the `bus_rd` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | One-cycle write strobe |
| bus_rd | input | 1 | One-cycle read strobe |
| bus_addr | input | 15 | Byte address |
| bus_wdata | input | 8 | Write data |
| sect_sel | input | 8 | Array sector selects, active high |
| arr_rdata | input | 8 | Main-array read data for `bus_addr` |
| rd_data | output | 8 | Registered read data |
| rd_valid | output | 1 | High in the cycle after a read |

## Verification
The bench walks through every way an unlock can fail: a wrong data byte on the second write, and a wrong address on the third. A design that kept a partial unlock would wrongly return row bytes after a later key write. It then reads all 64 row indices, and checks reads with bit 6 set and with no sector select. A design that confused the index bit with the select would show row data there, or would leave row mode. Finally it checks that a stray write in row mode does nothing, that the return command exits, and that a reset in the middle of row mode comes back in normal mode.

// File: rtl/otp_row_seq_pkg.sv
package otp_row_seq_pkg;

  typedef enum logic [1:0] {
    ST_NORM = 2'd0,
    ST_KEY1 = 2'd1,
    ST_KEY2 = 2'd2,
    ST_OTP  = 2'd3
  } seq_state_e;

  // Fixed contents of the row: byte k = 7*k + seed, modulo 256.
  function automatic logic [7:0] row_preload(input int unsigned k, input logic [7:0] seed);
    logic [7:0] prod;
    prod = 8'((k * 7) & 255);
    return prod + seed;
  endfunction

endpackage

// File: rtl/otp_unlock_fsm.sv
module otp_unlock_fsm
  import otp_row_seq_pkg::*;
#(
  parameter int          ADDR_W   = 15,
  parameter int          DATA_W   = 8,
  parameter logic [14:0] K1_ADDR  = 15'h0555,
  parameter logic [7:0]  K1_DATA  = 8'hAA,
  parameter logic [14:0] K2_ADDR  = 15'h02AA,
  parameter logic [7:0]  K2_DATA  = 8'h55,
  parameter logic [14:0] K3_ADDR  = 15'h0555,
  parameter logic [7:0]  K3_DATA  = 8'h90,
  parameter logic [7:0]  RET_DATA = 8'hF0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output seq_state_e        state
);

  logic       hit1, hit2, hit3, hit_ret;
  seq_state_e st_q, st_d;

  assign hit1    = (addr == ADDR_W'(K1_ADDR)) && (wdata == DATA_W'(K1_DATA));
  assign hit2    = (addr == ADDR_W'(K2_ADDR)) && (wdata == DATA_W'(K2_DATA));
  assign hit3    = (addr == ADDR_W'(K3_ADDR)) && (wdata == DATA_W'(K3_DATA));
  assign hit_ret = (wdata == DATA_W'(RET_DATA));

  // Next-state logic: only write cycles move the sequence.
  always_comb begin
    st_d = st_q;
    if (wr_en) begin
      unique case (st_q)
        ST_NORM: if (hit1) st_d = ST_KEY1;
        ST_KEY1: st_d = hit2 ? ST_KEY2 : ST_NORM;
        ST_KEY2: st_d = hit3 ? ST_OTP  : ST_NORM;
        ST_OTP:  if (hit_ret) st_d = ST_NORM;
        default: st_d = ST_NORM;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_NORM;
    else        st_q <= st_d;
  end

  assign state = st_q;

endmodule

// File: rtl/otp_row_store.sv
module otp_row_store
  import otp_row_seq_pkg::*;
#(
  parameter int         ROW_DEPTH = 64,
  parameter int         DATA_W    = 8,
  parameter logic [7:0] SEED      = 8'h5C,
  localparam int        IDX_W     = $clog2(ROW_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  idx,
  output logic [DATA_W-1:0] rd_byte
);

  logic [DATA_W-1:0] row_q [ROW_DEPTH];

  // One register per byte, loaded at reset and held afterwards.
  for (genvar g = 0; g < ROW_DEPTH; g++) begin : g_cell
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) row_q[g] <= DATA_W'(row_preload(g, SEED));
      else        row_q[g] <= row_q[g];
    end
  end

  assign rd_byte = row_q[idx];

endmodule

// File: rtl/otp_read_steer.sv
module otp_read_steer #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic              use_otp,
  input  logic [DATA_W-1:0] otp_byte,
  input  logic [DATA_W-1:0] arr_byte,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);

  logic [DATA_W-1:0] data_q, data_d;
  logic              valid_q;

  always_comb begin
    data_d = data_q;
    if (rd_en) data_d = use_otp ? otp_byte : arr_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      data_q  <= data_d;
      valid_q <= rd_en;
    end
  end

  assign rd_data  = data_q;
  assign rd_valid = valid_q;

endmodule

// File: rtl/otp_row_seq.sv
module otp_row_seq
  import otp_row_seq_pkg::*;
#(
  parameter int          ADDR_W    = 15,
  parameter int          DATA_W    = 8,
  parameter int          NSECT     = 8,
  parameter int          ROW_DEPTH = 64,
  parameter logic [7:0]  SEED      = 8'h5C,
  parameter logic [14:0] K1_ADDR   = 15'h0555,
  parameter logic [7:0]  K1_DATA   = 8'hAA,
  parameter logic [14:0] K2_ADDR   = 15'h02AA,
  parameter logic [7:0]  K2_DATA   = 8'h55,
  parameter logic [14:0] K3_ADDR   = 15'h0555,
  parameter logic [7:0]  K3_DATA   = 8'h90,
  parameter logic [7:0]  RET_DATA  = 8'hF0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [NSECT-1:0]  sect_sel,
  input  logic [DATA_W-1:0] arr_rdata,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);

  localparam int IDX_W   = $clog2(ROW_DEPTH);
  localparam int SEL_BIT = IDX_W;

  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rst_sync_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  seq_state_e        st_q;
  logic [DATA_W-1:0] otp_byte;
  logic              use_otp;

  otp_unlock_fsm #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .K1_ADDR (K1_ADDR),
    .K1_DATA (K1_DATA),
    .K2_ADDR (K2_ADDR),
    .K2_DATA (K2_DATA),
    .K3_ADDR (K3_ADDR),
    .K3_DATA (K3_DATA),
    .RET_DATA(RET_DATA)
  ) u_fsm (
    .clk  (clk),
    .rst_n(rst_sync_n),
    .wr_en(bus_wr),
    .addr (bus_addr),
    .wdata(bus_wdata),
    .state(st_q)
  );

  otp_row_store #(
    .ROW_DEPTH(ROW_DEPTH),
    .DATA_W   (DATA_W),
    .SEED     (SEED)
  ) u_row (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .idx    (bus_addr[IDX_W-1:0]),
    .rd_byte(otp_byte)
  );

  // Row data only in row mode, with a sector selected and the select bit clear.
  assign use_otp = (st_q == ST_OTP) && (|sect_sel) && !bus_addr[SEL_BIT];

  otp_read_steer #(
    .DATA_W(DATA_W)
  ) u_steer (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .rd_en   (bus_rd),
    .use_otp (use_otp),
    .otp_byte(otp_byte),
    .arr_byte(arr_rdata),
    .rd_data (rd_data),
    .rd_valid(rd_valid)
  );

endmodule

// File: rtl/otp_row_seq_chk.sv
module otp_row_seq_chk
  import otp_row_seq_pkg::*;
#(
  parameter int          ADDR_W   = 15,
  parameter int          DATA_W   = 8,
  parameter int          NSECT    = 8,
  parameter int          SEL_BIT  = 6,
  parameter logic [7:0]  SEED     = 8'h5C,
  parameter logic [14:0] K3_ADDR  = 15'h0555,
  parameter logic [7:0]  K3_DATA  = 8'h90,
  parameter logic [7:0]  RET_DATA = 8'hF0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [NSECT-1:0]  sect_sel,
  input logic [DATA_W-1:0] arr_rdata,
  input logic [DATA_W-1:0] rd_data,
  input logic              rd_valid,
  input seq_state_e        st
);

  // R8
  rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> rd_valid);

  // R8
  rd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> (!rd_valid && $stable(rd_data)));

  // R9
  norm_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && st != ST_OTP) |=> (rd_data == $past(arr_rdata)));

  // R4
  row_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && st == ST_OTP && (|sect_sel) && !bus_addr[SEL_BIT])
      |=> (rd_data == DATA_W'(row_preload(int'($past(bus_addr[SEL_BIT-1:0])), SEED))));

  // R5
  hi_bit_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_wr && st == ST_OTP && bus_addr[SEL_BIT])
      |=> (st == ST_OTP && rd_data == $past(arr_rdata)));

  // R7
  ret_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && st == ST_OTP && bus_wdata == DATA_W'(RET_DATA)) |=> (st == ST_NORM));

  // R2
  key3_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && st == ST_KEY2 && bus_addr == ADDR_W'(K3_ADDR) && bus_wdata == DATA_W'(K3_DATA))
      |=> (st == ST_OTP));

  // R3
  key_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && st == ST_KEY2 && bus_wdata != DATA_W'(K3_DATA)) |=> (st == ST_NORM));

endmodule

bind otp_row_seq otp_row_seq_chk #(
  .ADDR_W  (ADDR_W),
  .DATA_W  (DATA_W),
  .NSECT   (NSECT),
  .SEL_BIT (SEL_BIT),
  .SEED    (SEED),
  .K3_ADDR (K3_ADDR),
  .K3_DATA (K3_DATA),
  .RET_DATA(RET_DATA)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .bus_wr   (bus_wr),
  .bus_rd   (bus_rd),
  .bus_addr (bus_addr),
  .bus_wdata(bus_wdata),
  .sect_sel (sect_sel),
  .arr_rdata(arr_rdata),
  .rd_data  (rd_data),
  .rd_valid (rd_valid),
  .st       (st_q)
);

// File: tb/tb_otp_row_seq.sv
`timescale 1ns/1ps
module tb_otp_row_seq;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr, bus_rd;
  logic [14:0] bus_addr;
  logic [7:0]  bus_wdata, sect_sel, arr_rdata, rd_data;
  logic        rd_valid;
  int          total = 0;
  int          bad   = 0;

  always #2 clk = ~clk;

  // Stand-in array: data depends on the address only.
  assign arr_rdata = bus_addr[7:0] ^ 8'h3C;

  otp_row_seq dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .sect_sel(sect_sel),
    .arr_rdata(arr_rdata), .rd_data(rd_data), .rd_valid(rd_valid)
  );

  // op: 0 write, 1 read expecting row byte, 2 read expecting array data
  typedef struct packed {
    logic [1:0]  op;
    logic [14:0] addr;
    logic [7:0]  wd;
    logic [7:0]  sel;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VEC [NV] = '{
    '{2'd2, 15'h0123, 8'h00, 8'h01, 8'd9},  // R9 normal read
    '{2'd0, 15'h0555, 8'hAA, 8'h00, 8'd2},  // R2 key 1
    '{2'd2, 15'h0010, 8'h00, 8'h01, 8'd2},  // R2 read between keys
    '{2'd0, 15'h02AA, 8'h55, 8'h00, 8'd2},  // R2 key 2
    '{2'd0, 15'h0555, 8'h90, 8'h00, 8'd2},  // R2 key 3
    '{2'd1, 15'h0005, 8'h00, 8'h01, 8'd4},  // R4
    '{2'd1, 15'h003F, 8'h00, 8'h80, 8'd4},  // R4 last index
    '{2'd2, 15'h0045, 8'h00, 8'h02, 8'd5},  // R5 bit 6 set
    '{2'd1, 15'h0006, 8'h00, 8'h02, 8'd5},  // R5 still in row mode
    '{2'd2, 15'h0007, 8'h00, 8'h00, 8'd6},  // R6 no sector
    '{2'd0, 15'h0100, 8'h12, 8'h00, 8'd7},  // R7 stray write
    '{2'd1, 15'h0008, 8'h00, 8'h04, 8'd7},  // R7 still in row mode
    '{2'd0, 15'h0000, 8'hF0, 8'h00, 8'd7},  // R7 return
    '{2'd2, 15'h0008, 8'h00, 8'h04, 8'd7},  // R7 back to array
    '{2'd0, 15'h0555, 8'hAA, 8'h00, 8'd3},  // R3 key 1
    '{2'd0, 15'h02AA, 8'h00, 8'h00, 8'd3},  // R3 bad data
    '{2'd0, 15'h0555, 8'h90, 8'h00, 8'd3},  // R3 key 3 alone
    '{2'd2, 15'h0009, 8'h00, 8'h01, 8'd3},  // R3 no entry
    '{2'd0, 15'h0555, 8'hAA, 8'h00, 8'd3},  // R3 key 1
    '{2'd0, 15'h02AA, 8'h55, 8'h00, 8'd3},  // R3 key 2
    '{2'd0, 15'h0554, 8'h90, 8'h00, 8'd3},  // R3 bad address
    '{2'd2, 15'h000A, 8'h00, 8'h01, 8'd3}   // R3 no entry
  };

  function automatic logic [7:0] exp_row(input int k);
    return 8'((k * 7 + 'h5C) & 255);
  endfunction

  task automatic check(input int req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL R%0d: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [14:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  // Result registered at the edge after the strobe; sampled at the next falling edge.
  task automatic do_read(input logic [14:0] a, input logic [7:0] s,
                         input int req, input logic [7:0] exp);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a; sect_sel = s;
    @(negedge clk);
    bus_rd = 1'b0;
    check(req, {7'd0, rd_valid}, 8'd1);
    check(req, rd_data, exp);
  endtask

  task automatic unlock();
    do_write(15'h0555, 8'hAA);
    do_write(15'h02AA, 8'h55);
    do_write(15'h0555, 8'h90);
  endtask

  task automatic apply_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    // R1: outputs cleared while reset is held
    check(1, {7'd0, rd_valid}, 8'd0);
    check(1, rd_data, 8'h00);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #400000;
    total++; bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] held;
    rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0;
    bus_addr = '0; bus_wdata = '0; sect_sel = '0;
    apply_reset();

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].op == 2'd0) do_write(VEC[i].addr, VEC[i].wd);
      else if (VEC[i].op == 2'd1)
        do_read(VEC[i].addr, VEC[i].sel, int'(VEC[i].req), exp_row(int'(VEC[i].addr[5:0])));
      else
        do_read(VEC[i].addr, VEC[i].sel, int'(VEC[i].req), VEC[i].addr[7:0] ^ 8'h3C);
    end

    // R4: every index, rotating the active sector select
    unlock();
    for (int k = 0; k < 64; k++)
      do_read(15'(k), 8'(1 << (k % 8)), 4, exp_row(k));

    // R8: no strobe -> no valid, data held
    held = rd_data;
    @(negedge clk);
    check(8, {7'd0, rd_valid}, 8'd0);
    check(8, rd_data, held);

    // R1: reset in row mode returns to normal reads
    apply_reset();
    do_read(15'h0011, 8'h01, 1, 8'h11 ^ 8'h3C);

    // R7: exit via return at a key address too
    unlock();
    do_read(15'h0020, 8'h08, 7, exp_row(32));
    do_write(15'h0555, 8'hF0);
    do_read(15'h0020, 8'h08, 7, 8'h20 ^ 8'h3C);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule